// File: doc/BRIEF.md
# Count-Down Timer Channel with Absolute Timestamp Target

This block is one timer channel for a chip-level timer complex. A small register port sets up a reload value, a periodic mode and an enable. It also selects which of several tick pulses drives a down-counter, and holds a compare value for a free-running system timestamp. The channel raises its interrupt in two cases: when the down-counter expires, and when the timestamp equals the programmed target. Both cases set a single sticky pending flag. Software clears the flag by writing to the status register.

The timestamp target lets software place an event at an exact point on the shared time base. It is not tied to when the channel was armed. If the periodic mode is combined with an armed target, the first event lands on the target and the count-down then repeats at the reload interval. This gives a pulse train aligned to an absolute time, such as a once-per-second strobe on whole seconds.

Top module: `abs_target_timer`

## Requirements
- R1: After reset every readable register returns zero, the interrupt output is low and the target is not armed.
- R2: Register offsets: 0x00 control (bit 31 enable, bit 30 periodic, bits [24:0] reload), 0x04 tick-source select (bits [1:0]), 0x08 status (bit 0 pending), 0x0C timestamp target (bits [29:0]), 0x10 counter value. Written fields read back unchanged, and unused bits read as zero.
- R3: On a rising edge of enable the counter loads the reload value. The write lands on clock edge k, the load on edge k+1, and ticks seen at edge k+1 are not counted.
- R4: While the channel is enabled and running, each tick on the selected source lowers the counter by one. Ticks on sources that are not selected have no effect.
- R5: In one-shot mode, a selected tick with the counter at zero sets pending. The count-down then stops with the counter at zero, and later ticks do nothing.
- R6: In periodic mode, a selected tick at zero sets pending and reloads the counter, so events come every reload+1 ticks.
- R7: Writing the target arms it. While enabled and armed, a cycle where the timestamp input equals the target sets pending and disarms. A one-shot target fires once until it is written again.
- R8: In periodic mode with the target armed, the counter is held. The timestamp match reloads it and starts the periodic count-down.
- R9: Writing 1 to status bit 0 clears pending, and writing 0 there leaves it unchanged. If an event and a clear fall in the same cycle, pending stays set.
- R10: The interrupt output is pending gated by enable. Clearing enable freezes the counter and keeps pending.
- R11: Reads have no side effects, and writes to the counter offset are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_src | input | NSRC (4) | Single-cycle tick pulses, one per source |
| tstamp | input | TS_W (30) | Low bits of the system timestamp counter |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the edge that samples it. The enable load comes one edge later, so the bench waits one idle cycle before it reads the counter. Tick, timestamp-match and clear effects are visible in the cycle right after the edge that sampled them. The bench drives every stimulus at a falling edge and reads back at the next falling edge, or after the idle cycle for the enable load. Random runs compare the counter and pending state against bench functions of reload, tick count and mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_W = 5;
   localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_SRC  = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_TGT  = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h10;
   localparam int BIT_EN   = 31;
   localparam int BIT_PER  = 30;
   localparam int BIT_PEND = 0;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 25,
   parameter int TS_W   = 30,
   parameter int SEL_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pend,
   input  logic [CNT_W-1:0]  cnt,
   output logic              en,
   output logic              per,
   output logic [CNT_W-1:0]  reload,
   output logic [SEL_W-1:0]  sel,
   output logic [TS_W-1:0]   tgt,
   output logic              tgt_wr,
   output logic              clr,
   output logic [DATA_W-1:0] rdata
);
   assign tgt_wr = wr && (addr == OFS_TGT);
   assign clr    = wr && (addr == OFS_STAT) && wdata[BIT_PEND];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         per    <= 1'b0;
         reload <= '0;
         sel    <= '0;
         tgt    <= '0;
      end else if (wr) begin
         case (addr)
            OFS_CTRL: begin
               en     <= wdata[BIT_EN];
               per    <= wdata[BIT_PER];
               reload <= wdata[CNT_W-1:0];
            end
            OFS_SRC: sel <= wdata[SEL_W-1:0];
            OFS_TGT: tgt <= wdata[TS_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_CTRL: begin
            rdata[BIT_EN]      = en;
            rdata[BIT_PER]     = per;
            rdata[CNT_W-1:0]   = reload;
         end
         OFS_SRC:  rdata[SEL_W-1:0] = sel;
         OFS_STAT: rdata[BIT_PEND]  = pend;
         OFS_TGT:  rdata[TS_W-1:0]  = tgt;
         OFS_CNT:  rdata[CNT_W-1:0] = cnt;
         default:  rdata = '0;
      endcase
   end

   // R2: a control write is visible on the next cycle
   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS_CTRL) |=> (en == $past(wdata[BIT_EN]) && reload == $past(wdata[CNT_W-1:0])))
      else $error("control write not captured");
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
   parameter int CNT_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             per,
   input  logic [CNT_W-1:0] reload,
   input  logic             tick,
   input  logic             hold,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   logic en_d;
   logic run;
   logic load;
   logic step;

   assign load   = (en && !en_d) || restart;
   assign step   = en && run && !hold && tick && !load;
   assign expire = step && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d <= 1'b0;
         run  <= 1'b0;
         cnt  <= '0;
      end else begin
         en_d <= en;
         if (load) begin
            cnt <= reload;
            run <= 1'b1;
         end else if (step) begin
            if (cnt == '0) begin
               if (per) cnt <= reload;
               else     run <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assert_load_on_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |=> (cnt == $past(reload)))
      else $error("enable edge did not load reload value");

   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt != '0) |=> (cnt == $past(cnt) - 1'b1))
      else $error("counter did not step by one");

   assert_frozen_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt))
      else $error("counter moved while disabled");

   assert_held_for_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hold && !load) |=> $stable(cnt))
      else $error("counter moved while waiting for target");
endmodule

// File: rtl/tmr_target.sv
module tmr_target #(
   parameter int TS_W = 30
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [TS_W-1:0] tgt,
   input  logic            tgt_wr,
   input  logic [TS_W-1:0] tstamp,
   output logic            armed,
   output logic            hit
);
   assign hit = en && armed && (tstamp == tgt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed <= 1'b0;
      else if (tgt_wr) armed <= 1'b1;
      else if (hit)    armed <= 1'b0;
   end

   assert_fires_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !tgt_wr) |=> !hit)
      else $error("target fired twice without rewrite");

   assert_write_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_wr |=> armed)
      else $error("target write did not arm");
endmodule

// File: rtl/abs_target_timer.sv
module abs_target_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 25,
   parameter int TS_W   = 30,
   parameter int NSRC   = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NSRC-1:0]   tick_src,
   input  logic [TS_W-1:0]   tstamp,
   output logic              irq
);
   localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= BIT_PER) else $error("CNT_W out of range");
      assert (TS_W >= 1 && TS_W <= DATA_W)    else $error("TS_W out of range");
      assert (NSRC >= 1 && SEL_W < BIT_PER)   else $error("NSRC out of range");
      assert (DATA_W == 32)                   else $error("DATA_W must be 32");
   end

   logic             en, per, tgt_wr, clr, tick, armed, hit, expire, pend;
   logic [CNT_W-1:0] reload, cnt;
   logic [SEL_W-1:0] sel;
   logic [TS_W-1:0]  tgt;

   tmr_regs #(.CNT_W(CNT_W), .TS_W(TS_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .pend(pend), .cnt(cnt), .en(en), .per(per), .reload(reload), .sel(sel),
      .tgt(tgt), .tgt_wr(tgt_wr), .clr(clr), .rdata(reg_rdata)
   );

   generate
      if (NSRC == 1) begin : g_one_src
         assign tick = tick_src[0] && (sel == '0);
      end else begin : g_src_mux
         assign tick = (int'(sel) < NSRC) ? tick_src[sel] : 1'b0;
      end
   endgenerate

   tmr_target #(.TS_W(TS_W)) target_i (
      .clk(clk), .rst_n(rst_n), .en(en), .tgt(tgt), .tgt_wr(tgt_wr),
      .tstamp(tstamp), .armed(armed), .hit(hit)
   );

   tmr_countdown #(.CNT_W(CNT_W)) count_i (
      .clk(clk), .rst_n(rst_n), .en(en), .per(per), .reload(reload), .tick(tick),
      .hold(per && armed), .restart(hit && per), .cnt(cnt), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pend <= 1'b0;
      else if (expire || hit)  pend <= 1'b1;
      else if (clr)            pend <= 1'b0;
   end

   assign irq = pend && en;

   assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire || hit) |=> pend)
      else $error("event lost");

   assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !expire && !hit) |=> !pend)
      else $error("clear ignored");

   assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend)
      else $error("pending dropped without clear");
endmodule

// File: tb/abs_target_timer_tb_top.sv
module abs_target_timer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_CTRL = 5'h00, A_SRC = 5'h04, A_STAT = 5'h08,
                          A_TGT = 5'h0C, A_CNT = 5'h10;
   localparam logic [31:0] EN = 32'h8000_0000, PER = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  tick_src = '0;
   logic [29:0] tstamp = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   abs_target_timer dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_src(tick_src),
      .tstamp(tstamp), .irq(irq)
   );

   function automatic int unsigned exp_cnt(int unsigned rl, int unsigned k, bit periodic);
      if (k <= rl) return rl - k;
      if (!periodic) return 0;
      return rl - (k % (rl + 1));
   endfunction

   function automatic int unsigned exp_events(int unsigned rl, int unsigned k, bit periodic);
      if (!periodic) return (k > rl) ? 1 : 0;
      return k / (rl + 1);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(logic [3:0] v);
      tick_src = v;
      @(negedge clk);
      tick_src = '0;
   endtask

   task automatic expect_reg(string req, logic [4:0] a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd2024));
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      expect_reg("R1 ctrl", A_CTRL, 0);
      expect_reg("R1 src", A_SRC, 0);
      expect_reg("R1 stat", A_STAT, 0);
      expect_reg("R1 tgt", A_TGT, 0);
      expect_reg("R1 cnt", A_CNT, 0);
      check("R1 irq", {31'd0, irq}, 0);

      // R2 readback of control and source select (disabled)
      wr(A_CTRL, PER | 32'h3FFF_FFFF);
      expect_reg("R2 ctrl", A_CTRL, PER | 32'h01FF_FFFF);
      wr(A_SRC, 32'hFFFF_FFFE);
      expect_reg("R2 src", A_SRC, 2);
      wr(A_CTRL, 0);

      // R4 R5 R6 random count-down runs checked against bench functions
      for (int it = 0; it < 12; it++) begin
         int unsigned rl = 1 + $urandom_range(0, 14);
         int unsigned k  = $urandom_range(0, 3 * (rl + 1));
         bit per_m = 1'($urandom_range(0, 1));
         int unsigned s = $urandom_range(0, 3);
         wr(A_CTRL, 0);
         wr(A_SRC, s);
         wr(A_CTRL, EN | (per_m ? PER : 0) | rl);
         cyc();
         wr(A_STAT, 1);
         for (int t = 0; t < int'(k); t++) begin
            logic [3:0] noise = 4'($urandom_range(0, 15));
            pulse(noise & ~(4'b1 << s));
            pulse(4'b1 << s);
         end
         expect_reg(per_m ? "R6 random cnt" : "R5 random cnt", A_CNT, exp_cnt(rl, k, per_m));
         expect_reg("R4 random pend", A_STAT, (exp_events(rl, k, per_m) > 0) ? 1 : 0);
      end

      // R3 enable edge loads reload; R4 unselected ticks ignored
      wr(A_CTRL, 0);
      wr(A_SRC, 2);
      wr(A_STAT, 1);
      wr(A_CTRL, EN | 5);
      cyc();
      expect_reg("R3 load", A_CNT, 5);
      pulse(4'b1011);
      expect_reg("R4 unselected", A_CNT, 5);
      repeat (3) pulse(4'b0100);
      expect_reg("R4 step", A_CNT, 2);
      wr(A_CTRL, EN | 9);
      expect_reg("R3 no reload while enabled", A_CNT, 2);
      repeat (2) pulse(4'b0100);
      expect_reg("R5 at zero no event", A_STAT, 0);
      pulse(4'b0100);
      expect_reg("R5 event", A_STAT, 1);
      check("R10 irq high", {31'd0, irq}, 1);
      repeat (3) pulse(4'b0100);
      expect_reg("R5 stopped", A_CNT, 0);

      // R10 disable keeps pending, masks irq
      wr(A_CTRL, 9);
      check("R10 irq masked", {31'd0, irq}, 0);
      expect_reg("R10 pend kept", A_STAT, 1);

      // R9 clear semantics
      wr(A_STAT, 0);
      expect_reg("R9 write zero", A_STAT, 1);
      wr(A_STAT, 1);
      expect_reg("R9 clear", A_STAT, 0);

      // R10 frozen counter
      wr(A_CTRL, EN | 9);
      cyc();
      repeat (2) pulse(4'b0100);
      wr(A_CTRL, 9);
      repeat (3) pulse(4'b0100);
      expect_reg("R10 frozen", A_CNT, 7);

      // R6 periodic reload
      wr(A_CTRL, EN | PER | 3);
      cyc();
      repeat (4) pulse(4'b0100);
      expect_reg("R6 reload", A_CNT, 3);
      expect_reg("R6 event", A_STAT, 1);
      wr(A_STAT, 1);
      repeat (3) pulse(4'b0100);
      expect_reg("R6 at zero", A_CNT, 0);
      // R9 event and clear in the same cycle
      reg_addr = A_STAT; reg_wdata = 1; reg_wr = 1'b1; tick_src = 4'b0100;
      cyc();
      reg_wr = 1'b0; tick_src = '0;
      expect_reg("R9 event wins", A_STAT, 1);

      // R7 one-shot target
      wr(A_CTRL, 0);
      wr(A_STAT, 1);
      tstamp = 30'd5;
      wr(A_TGT, 1000);
      wr(A_CTRL, EN | 32'h01FF_FFFF);
      tstamp = 30'd999; cyc();
      expect_reg("R7 before target", A_STAT, 0);
      tstamp = 30'd1000; cyc();
      expect_reg("R7 target hit", A_STAT, 1);
      wr(A_STAT, 1);
      tstamp = 30'd1001; cyc();
      tstamp = 30'd1000; cyc();
      expect_reg("R7 fires once", A_STAT, 0);
      tstamp = 30'd5;
      wr(A_TGT, 1000);
      tstamp = 30'd1000; cyc();
      expect_reg("R7 rearmed", A_STAT, 1);

      // R8 periodic with target: held until match, then periodic
      wr(A_CTRL, 0);
      wr(A_STAT, 1);
      tstamp = 30'd10;
      wr(A_TGT, 2000);
      wr(A_CTRL, EN | PER | 4);
      cyc();
      repeat (6) pulse(4'b0100);
      expect_reg("R8 held cnt", A_CNT, 4);
      expect_reg("R8 held pend", A_STAT, 0);
      tstamp = 30'd2000; cyc();
      expect_reg("R8 target first", A_STAT, 1);
      expect_reg("R8 restart cnt", A_CNT, 4);
      wr(A_STAT, 1);
      repeat (4) pulse(4'b0100);
      expect_reg("R8 no early event", A_STAT, 0);
      pulse(4'b0100);
      expect_reg("R8 periodic event", A_STAT, 1);
      expect_reg("R8 periodic reload", A_CNT, 4);

      // R11 counter write ignored, reads have no effect
      wr(A_CTRL, 0);
      rd(A_CNT, v);
      wr(A_CNT, 32'h0012_3456);
      expect_reg("R11 cnt write ignored", A_CNT, v);
      rd(A_STAT, v); rd(A_STAT, v);
      expect_reg("R11 read no effect", A_STAT, 1);

      // R2 target readback, upper bits zero
      wr(A_TGT, 32'hFFFF_FFFF);
      expect_reg("R2 tgt", A_TGT, 32'h3FFF_FFFF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule